// File: doc/BRIEF.md
# Configurable Synchronous Serial Controller

This block moves full-duplex serial words between a simple register port and three serial lines: a shift clock, a data output and a data input. It acts either as the clock source (master) or as a follower of an external clock (slave). Software picks the role, the frame width (8 or 16 bits), the bit order and a power-of-two clock divider through a control register, then exchanges words through one data address: writes fill a one-word transmit holding buffer and reads drain a one-word receive holding buffer.

The shift clock idles low; the incoming bit is captured on each rising clock edge and the outgoing bit moves on each falling edge. As master, the controller begins a frame on its own as soon as it is enabled and a transmit word is waiting, and it can drive an active-low select line for the duration of the frame. As slave, it shifts only while selected, where the select comes from an input pin or from a software bit. Three interrupt lines (receive word waiting, transmit buffer free, overrun error) each pass through their own enable.

Top module: `sync_serial_ctrl`

Register map (16-bit): address 0 CTRL, address 1 OPTS, address 2 DATA, address 3 STAT.

## Requirements
- R1: After reset CTRL reads 0, OPTS reads 0, STAT reads 0x0002 (only transmit-free, bit 1, set), all three interrupt lines are 0, sclk_o is 0 and ssel_n_o is 1.
- R2: In master mode the shift clock period is 2^(code+1) cycles of clk, where code is CTRL bits [4:2] (0 gives /2, 7 gives /256).
- R3: While CTRL bit 0 (enable) is 0 no frame runs: sclk_o stays low and a word written to DATA stays pending (STAT bit 1 stays 0); setting enable afterwards sends that word.
- R4: With CTRL bit 1 = 1 (master) and enable set, a pending transmit word starts a frame by itself; the clock idles low, sout_o changes only after falling edges and sin_i is captured at rising edges, full duplex.
- R5: CTRL bit 5 = 0 sends and assembles the most significant bit first; 1 sends and assembles the least significant bit first.
- R6: CTRL bit 6 = 0 gives 8-bit frames (received word zero-extended); 1 gives 16-bit frames.
- R7: In slave mode (CTRL bit 1 = 0) with CTRL bit 7 = 0, the controller shifts on edges of sclk_i while ssel_n_i is low, sending the pending transmit word, and ignores sclk_i while ssel_n_i is high.
- R8: With CTRL bit 7 = 1 the software select bit CTRL bit 8 replaces ssel_n_i: 0 means selected, 1 means not selected, whatever the pin does.
- R9: ssel_n_o goes low during a master frame only when OPTS bit 0 is 1; otherwise it stays high.
- R10: A DATA write loads the transmit buffer; a DATA read returns the last received word and clears STAT bit 0 (receive full).
- R11: irq_rx = STAT bit 0 gated by OPTS bit 1, irq_tx = STAT bit 1 gated by OPTS bit 2, irq_err = STAT bit 2 gated by OPTS bit 3.
- R12: A frame that ends while the receive buffer is full sets STAT bit 2 (overrun) and keeps the old received word; a STAT read clears the overrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on DATA and STAT) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| sclk_o | output | 1 | Shift clock driven in master mode |
| sclk_i | input | 1 | Shift clock received in slave mode |
| sout_o | output | 1 | Serial data out |
| sin_i | input | 1 | Serial data in |
| ssel_n_i | input | 1 | Active-low select input for slave mode |
| ssel_n_o | output | 1 | Active-low select output in master mode |
| irq_rx | output | 1 | Receive word waiting interrupt |
| irq_tx | output | 1 | Transmit buffer free interrupt |
| irq_err | output | 1 | Overrun interrupt |

## Verification
Master frames are run with non-symmetric words at divider codes 0, 1, 3 and 7 in both widths and both bit orders, so a swapped bit order, a lost upper byte or a wrong clock period each produce a distinct mismatch on the captured output word, the first wire bit or the measured period. Slave frames are driven with a slow external clock under pin select and software select, and with the select held inactive so that ignored clock edges show up as an unchanged status word. Back-to-back frames without a read separate overrun handling (old word kept, error line raised and cleared by a status read) from plain buffer overwrite.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  parameter int DATA_W = 16;
  localparam int IDX_W = $clog2(DATA_W);
  localparam int CODE_W = 3;

  typedef struct packed {
    logic             sw_lvl;
    logic             sw_sel;
    logic             wide;
    logic             lsb_first;
    logic [CODE_W-1:0] code;
    logic             master;
    logic             en;
  } ctrl_t;

  // highest bit index used by the selected frame width
  function automatic logic [IDX_W-1:0] last_idx(input logic wide);
    return wide ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W / 2 - 1);
  endfunction

  // buffer bit that travels at wire position i
  function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] i,
                                               input logic lsb_first,
                                               input logic wide);
    return lsb_first ? i : last_idx(wide) - i;
  endfunction

  // clk cycles in one half period of the shift clock
  function automatic int unsigned half_len(input logic [CODE_W-1:0] code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/ssc_baud.sv
module ssc_baud
  import ssc_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] code,
  output logic          tick
);
  localparam int CNT_W = (1 << CW) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(half_len(code) - 1);
  assign tick  = run && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  p_tick_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != '0 && $past(run)) |=> (!tick || code == '0));
endmodule

// File: rtl/ssc_shifter.sv
module ssc_shifter
  import ssc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          master,
  input  logic          lsb_first,
  input  logic          wide,
  input  logic          tick,
  input  logic          start,
  input  logic          tx_avail,
  input  logic [DW-1:0] tx_data,
  input  logic          sel,
  input  logic          sclk_i,
  input  logic          sin_i,
  output logic          busy,
  output logic          sclk_o,
  output logic          sout_o,
  output logic          frame_done,
  output logic          slave_take,
  output logic [DW-1:0] rx_word
);
  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0] sync;
  logic [IW-1:0]     idx;
  logic [DW-1:0]     sh;
  logic [DW-1:0]     src;
  logic [IW-1:0]     pos;
  logic              last;
  logic              rise_s, fall_s;
  logic              m_fall, s_fall;

  assign pos    = bit_pos(idx, lsb_first, wide);
  assign last   = (idx == last_idx(wide));
  assign rise_s = sync[1] && !sync[2];
  assign fall_s = !sync[1] && sync[2];
  assign m_fall = en && master && busy && tick && sclk_o;
  assign s_fall = en && !master && sel && busy && fall_s;
  assign frame_done = (m_fall || s_fall) && last;
  assign slave_take = en && !master && sel && rise_s && !busy && tx_avail;

  assign src    = (!master && !busy) ? (tx_avail ? tx_data : '0) : sh;
  assign sout_o = src[pos];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[SYNC_N-2:0], sclk_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk_o  <= 1'b0;
      idx     <= '0;
      sh      <= '0;
      rx_word <= '0;
    end else if (!en) begin
      busy   <= 1'b0;
      sclk_o <= 1'b0;
      idx    <= '0;
    end else if (master) begin
      if (start) begin
        busy    <= 1'b1;
        sclk_o  <= 1'b0;
        idx     <= '0;
        sh      <= tx_data;
        rx_word <= '0;
      end else if (busy && tick) begin
        sclk_o <= !sclk_o;
        if (!sclk_o) begin
          rx_word[pos] <= sin_i;
        end else if (last) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end else begin
      sclk_o <= 1'b0;
      if (!sel) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        if (rise_s) begin
          if (!busy) begin
            busy    <= 1'b1;
            sh      <= tx_avail ? tx_data : '0;
            rx_word <= '0;
          end
          rx_word[pos] <= sin_i;
        end else if (fall_s && busy) begin
          if (last) begin
            busy <= 1'b0;
            idx  <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk_o);
  p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !sclk_o));
  p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/sync_serial_ctrl.sv
module sync_serial_ctrl
  import ssc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk_o,
  input  logic        sclk_i,
  output logic        sout_o,
  input  logic        sin_i,
  input  logic        ssel_n_i,
  output logic        ssel_n_o,
  output logic        irq_rx,
  output logic        irq_tx,
  output logic        irq_err
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_OPTS = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl;
  logic              ss_oe, ie_rx, ie_tx, ie_err;
  logic [DATA_W-1:0] tx_buf, rx_buf, rx_word;
  logic              tx_full, rx_full, overrun;
  logic              busy, tick, start, frame_done, slave_take, sel;
  logic              wr_data, rd_data, rd_stat;
  logic [DATA_W-1:0] rx_masked;

  assign wr_data = bus_wr && bus_addr == A_DATA;
  assign rd_data = bus_rd && bus_addr == A_DATA;
  assign rd_stat = bus_rd && bus_addr == A_STAT;
  assign sel     = ctrl.sw_sel ? !ctrl.sw_lvl : !ssel_n_i;
  assign start   = ctrl.en && ctrl.master && tx_full && !busy;
  assign rx_masked = ctrl.wide ? rx_word : (rx_word & DATA_W'((1 << (DATA_W / 2)) - 1));

  ssc_baud u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy && ctrl.master && ctrl.en),
    .code (ctrl.code),
    .tick (tick)
  );

  ssc_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl.en),
    .master    (ctrl.master),
    .lsb_first (ctrl.lsb_first),
    .wide      (ctrl.wide),
    .tick      (tick),
    .start     (start),
    .tx_avail  (tx_full),
    .tx_data   (tx_buf),
    .sel       (sel),
    .sclk_i    (sclk_i),
    .sin_i     (sin_i),
    .busy      (busy),
    .sclk_o    (sclk_o),
    .sout_o    (sout_o),
    .frame_done(frame_done),
    .slave_take(slave_take),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      ss_oe  <= 1'b0;
      ie_rx  <= 1'b0;
      ie_tx  <= 1'b0;
      ie_err <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (bus_addr == A_OPTS) {ie_err, ie_tx, ie_rx, ss_oe} <= bus_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
    end else if (wr_data) begin
      tx_buf  <= bus_wdata;
      tx_full <= 1'b1;
    end else if (start || slave_take) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (rd_stat) overrun <= 1'b0;
      if (frame_done && rx_full && !rd_data) begin
        overrun <= 1'b1;
      end else if (frame_done) begin
        rx_buf  <= rx_masked;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = 16'(ctrl);
      A_OPTS:  bus_rdata = {12'd0, ie_err, ie_tx, ie_rx, ss_oe};
      A_DATA:  bus_rdata = rx_buf;
      default: bus_rdata = {12'd0, busy, overrun, !tx_full, rx_full};
    endcase
  end

  assign ssel_n_o = !(ctrl.master && ss_oe && busy);
  assign irq_rx   = ie_rx && rx_full;
  assign irq_tx   = ie_tx && !tx_full;
  assign irq_err  = ie_err && overrun;

  p_overrun_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full && !rd_data) |=> ($stable(rx_buf) && overrun));
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !wr_data && tx_full) |=> tx_full);
  p_ssel_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ssel_n_o |-> (ctrl.master && busy));
  p_err_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> overrun);
  p_take_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_data) |=> !tx_full);
endmodule

// File: tb/sim_sync_serial_ctrl.sv
`timescale 1ns/1ps
module sim_sync_serial_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        sclk_o, sout_o, ssel_n_o, irq_rx, irq_tx, irq_err;
  logic        sclk_i = 1'b0, ssel_n_i = 1'b1, sin_drv = 1'b0;
  logic        sin_i;

  int checks = 0, errors = 0;
  bit b_wide = 0, b_lsb = 0, slv_mode = 0;
  logic [15:0] b_word = 16'd0, cap = 16'd0;
  int m_idx = 0, frames = 0, rises = 0;
  logic [15:0] exp_tx[$];

  always #10 clk = ~clk;

  sync_serial_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk_o(sclk_o), .sclk_i(sclk_i), .sout_o(sout_o), .sin_i(sin_i),
    .ssel_n_i(ssel_n_i), .ssel_n_o(ssel_n_o),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_err(irq_err)
  );

  function automatic int nbits();
    return b_wide ? 16 : 8;
  endfunction
  function automatic int bpos(input int i);
    return b_lsb ? i : nbits() - 1 - i;
  endfunction
  function automatic logic [15:0] wmask(input logic [15:0] v);
    return b_wide ? v : {8'd0, v[7:0]};
  endfunction
  function automatic logic [15:0] ctl(input bit en, input bit ms, input logic [2:0] bd,
                                      input bit lsb, input bit wd, input bit ss, input bit sl);
    return {7'd0, sl, ss, wd, lsb, bd, ms, en};
  endfunction

  assign sin_i = slv_mode ? sin_drv : b_word[bpos(m_idx)];

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave-device model and monitor for master frames
  always @(posedge sclk_o) begin
    rises++;
    cap[bpos(m_idx)] = sout_o;
  end
  always @(negedge sclk_o) begin
    m_idx++;
    if (m_idx == nbits()) begin
      logic [15:0] e;
      e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 16'hxxxx;
      check(wmask(cap) === e, "R4 serial out word", wmask(cap), e);
      m_idx = 0;
      cap = 16'd0;
      frames++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    int g = 0;
    while (frames < target && g < 20000) begin
      @(negedge clk);
      g++;
    end
    repeat (4) @(negedge clk);
  endtask

  // master frame; returns measured period, select level and first wire bit
  task automatic mxfer(input logic [15:0] tx, input logic [15:0] slv, input bit do_read,
                       output int period, output logic ss_seen, output logic first_bit);
    logic [15:0] d;
    realtime t0;
    int fb;
    fb = frames;
    exp_tx.push_back(wmask(tx));
    b_word = slv;
    reg_write(2'd2, tx);
    @(posedge sclk_o);
    t0 = $realtime;
    ss_seen = ssel_n_o;
    first_bit = sout_o;
    @(posedge sclk_o);
    period = int'(($realtime - t0) / 20.0);
    wait_frames(fb + 1);
    if (do_read) begin
      reg_read(2'd2, d);
      check(d === wmask(slv), "R10 received word", d, wmask(slv));
    end
  endtask

  task automatic sxfer(input logic [15:0] in_w, output logic [15:0] got);
    got = 16'd0;
    for (int i = 0; i < nbits(); i++) begin
      sin_drv = in_w[bpos(i)];
      repeat (6) @(negedge clk);
      got[bpos(i)] = sout_o;
      sclk_i = 1'b1;
      repeat (8) @(negedge clk);
      sclk_i = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] d, got;
    int per, fb;
    logic ss, f0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd3, d); check(d === 16'h0002, "R1 status", d, 16'h0002);
    reg_read(2'd0, d); check(d === 16'h0000, "R1 ctrl", d, 16'h0000);
    reg_read(2'd1, d); check(d === 16'h0000, "R1 opts", d, 16'h0000);
    check({irq_rx, irq_tx, irq_err} === 3'b000, "R1 irqs", {13'd0, irq_rx, irq_tx, irq_err}, 16'd0);
    check(sclk_o === 1'b0 && ssel_n_o === 1'b1, "R1 lines", {14'd0, sclk_o, ssel_n_o}, 16'h0001);

    // R3 disabled: master selected, enable off
    b_wide = 0; b_lsb = 0;
    reg_write(2'd0, ctl(0, 1, 3'd0, 0, 0, 0, 0));
    b_word = 16'h0081;
    reg_write(2'd2, 16'h005A);
    fb = frames;
    rises = 0;
    repeat (200) @(negedge clk);
    check(rises == 0, "R3 no clock while disabled", 16'(rises), 16'd0);
    reg_read(2'd3, d); check(d[1] === 1'b0, "R3 word kept pending", {15'd0, d[1]}, 16'd0);
    exp_tx.push_back(16'h005A);
    reg_write(2'd0, ctl(1, 1, 3'd0, 0, 0, 0, 0));
    wait_frames(fb + 1);
    reg_read(2'd2, d); check(d === 16'h0081, "R3 sent after enable", d, 16'h0081);

    // R2 R4 R5 R9: code 0, msb first, select driven
    reg_write(2'd1, 16'h0001);
    mxfer(16'h00A5, 16'h003C, 1, per, ss, f0);
    check(per == 2, "R2 period code0", 16'(per), 16'd2);
    check(ss === 1'b0, "R9 select low in frame", {15'd0, ss}, 16'd0);
    check(f0 === 1'b1, "R5 msb first bit", {15'd0, f0}, 16'd1);

    // code 3, lsb first, select not driven
    b_lsb = 1;
    reg_write(2'd1, 16'h0000);
    reg_write(2'd0, ctl(1, 1, 3'd3, 1, 0, 0, 0));
    mxfer(16'h0006, 16'h00C1, 1, per, ss, f0);
    check(per == 16, "R2 period code3", 16'(per), 16'd16);
    check(ss === 1'b1, "R9 select idle when off", {15'd0, ss}, 16'd1);
    check(f0 === 1'b0, "R5 lsb first bit", {15'd0, f0}, 16'd0);

    // R6 16-bit, code 7, msb first
    b_wide = 1; b_lsb = 0;
    reg_write(2'd0, ctl(1, 1, 3'd7, 0, 1, 0, 0));
    mxfer(16'h8123, 16'hB00D, 1, per, ss, f0);
    check(per == 256, "R2 period code7", 16'(per), 16'd256);
    check(f0 === 1'b1, "R6 wide first bit", {15'd0, f0}, 16'd1);

    // R6 16-bit lsb, code 1
    b_lsb = 1;
    reg_write(2'd0, ctl(1, 1, 3'd1, 1, 1, 0, 0));
    mxfer(16'h7E01, 16'h4C3A, 1, per, ss, f0);
    check(per == 4, "R2 period code1", 16'(per), 16'd4);

    // R11 interrupt gating
    b_wide = 0; b_lsb = 0;
    reg_write(2'd0, ctl(1, 1, 3'd0, 0, 0, 0, 0));
    @(negedge clk);
    check(irq_tx === 1'b0, "R11 tx irq masked", {15'd0, irq_tx}, 16'd0);
    reg_write(2'd1, 16'h0004);
    @(negedge clk);
    check(irq_tx === 1'b1, "R11 tx irq enabled", {15'd0, irq_tx}, 16'd1);
    reg_write(2'd1, 16'h0002);
    mxfer(16'h0011, 16'h0022, 0, per, ss, f0);
    check(irq_rx === 1'b1, "R11 rx irq", {15'd0, irq_rx}, 16'd1);
    reg_read(2'd2, d); check(d === 16'h0022, "R10 read word", d, 16'h0022);
    @(negedge clk);
    check(irq_rx === 1'b0, "R10 read clears full", {15'd0, irq_rx}, 16'd0);

    // R12 overrun
    reg_write(2'd1, 16'h0008);
    mxfer(16'h0033, 16'h0044, 0, per, ss, f0);
    check(irq_err === 1'b0, "R12 no error yet", {15'd0, irq_err}, 16'd0);
    mxfer(16'h0055, 16'h0066, 0, per, ss, f0);
    check(irq_err === 1'b1, "R12 error irq", {15'd0, irq_err}, 16'd1);
    reg_read(2'd2, d); check(d === 16'h0044, "R12 old word kept", d, 16'h0044);
    reg_read(2'd3, d); check(d[2] === 1'b1, "R12 overrun flag", {15'd0, d[2]}, 16'd1);
    @(negedge clk);
    check(irq_err === 1'b0, "R12 cleared by status read", {15'd0, irq_err}, 16'd0);
    reg_write(2'd1, 16'h0000);

    // R7 slave, pin select, 8-bit msb
    slv_mode = 1;
    reg_write(2'd0, ctl(1, 0, 3'd0, 0, 0, 0, 0));
    reg_write(2'd2, 16'h00C3);
    ssel_n_i = 1'b0;
    sxfer(16'h0096, got);
    check(got === 16'h00C3, "R7 slave out word", got, 16'h00C3);
    reg_read(2'd2, d); check(d === 16'h0096, "R7 slave in word", d, 16'h0096);

    // R8 software select on, pin high, 16-bit lsb
    b_wide = 1; b_lsb = 1;
    ssel_n_i = 1'b1;
    reg_write(2'd0, ctl(1, 0, 3'd0, 1, 1, 1, 0));
    reg_write(2'd2, 16'hA1F0);
    sxfer(16'h1E5B, got);
    check(got === 16'hA1F0, "R8 sw select out word", got, 16'hA1F0);
    reg_read(2'd2, d); check(d === 16'h1E5B, "R8 sw select in word", d, 16'h1E5B);

    // R8 software deselect, pin low: edges ignored
    b_wide = 0; b_lsb = 0;
    ssel_n_i = 1'b0;
    reg_write(2'd0, ctl(1, 0, 3'd0, 0, 0, 1, 1));
    reg_write(2'd2, 16'h0077);
    sxfer(16'h00FF, got);
    reg_read(2'd3, d); check(d[1:0] === 2'b00, "R8 deselected ignores clock", {14'd0, d[1:0]}, 16'd0);

    // R7 pin high with hardware select: edges ignored
    ssel_n_i = 1'b1;
    reg_write(2'd0, ctl(1, 0, 3'd0, 0, 0, 0, 0));
    sxfer(16'h00FF, got);
    reg_read(2'd3, d); check(d[1:0] === 2'b00, "R7 pin high ignores clock", {14'd0, d[1:0]}, 16'd0);

    check(exp_tx.size() == 0, "R4 all frames seen", 16'(exp_tx.size()), 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule